// File: doc/BRIEF.md
# Product-to-Pulse-Rate Output Generator

This block turns a stream of signed product samples into pulse trains whose average rate follows the accumulated product. Each accepted sample is added to two accumulators that run side by side. The coarse accumulator has a large threshold and feeds a pair of active-low outputs. Those outputs take turns, so the second one falls half an output period after the first. That suits two-phase stepper drives or electromechanical counters. The fine accumulator has a smaller threshold and drives an active-high calibration output that runs at a higher rate.

Pulse widths are counted in clock cycles. At low rates each pulse has a fixed nominal width. When events come faster, each pulse shrinks to half the measured spacing between the events routed to that output, so an output always returns to idle between pulses. Events that arrive while a pulse is still running wait in a small pending counter and are never lost.

Samples enter over a valid/ready handshake. A sample is taken on a clock edge where both `s_valid` and `s_ready` are high. `s_ready` falls only when some output's pending store could overflow. While it is low, the source must hold `s_valid` high and `s_data` unchanged. The mode pin `mag_only` and the `rev_flag` output are plain level signals.

Top module: `prate_gen`

## Requirements
- R1: After reset, `lo_a_n` and `lo_b_n` are 1, `cal_pulse` is 0, `rev_flag` is 0 and `s_ready` is 1.
- R2: A sample is taken on a clock edge with `s_valid` and `s_ready` both high. `s_ready` is low only when an output holds PEND_MAX pending or in-flight events. While `s_valid` is high and `s_ready` is low, the source holds `s_valid` and `s_data`.
- R3: With `mag_only` = 1, the absolute value of each sample is added to each accumulator. When a sum reaches its threshold, that path emits one event and the threshold is subtracted, keeping the remainder.
- R4: With `mag_only` = 0, samples are added with their sign. A sum at or above +threshold emits an event and subtracts the threshold. A sum at or below -threshold emits an event and adds the threshold. Opposite samples of equal size therefore cancel.
- R5: Coarse events alternate between `lo_a_n` and `lo_b_n`, starting with `lo_a_n` after reset. At a steady event spacing S, the latest falling edges of the two outputs are S cycles apart.
- R6: A low output stays low for exactly LO_W cycles when events routed to it are at least 2*LO_W cycles apart, and for the first event after reset.
- R7: The width of each pulse is min(nominal, max(1, G/2)), where G is the most recent spacing between events routed to that output. Every output spends at least one idle cycle between two pulses.
- R8: `cal_pulse` is active high. It is driven by the fine accumulator (threshold CAL_THRESH, same mode rules) and is CAL_W cycles wide at low rates, shrinking under the R7 rule.
- R9: No event is dropped. An event that arrives during a pulse is issued once that pulse and one idle cycle have passed, and the pending count never exceeds PEND_MAX.
- R10: `rev_flag` changes only on a clock edge where a coarse event is emitted. It is then set to 1 exactly when `mag_only` = 1 and the triggering sample is negative, and to 0 otherwise.
- R11: Both thresholds are at least 2^(SW-1), so each sample yields at most one event per accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample available |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | SW | Signed product sample, two's complement |
| mag_only | input | 1 | 1: magnitude-only mode, 0: sign-and-magnitude mode |
| lo_a_n | output | 1 | First low-rate output, active low |
| lo_b_n | output | 1 | Second low-rate output, active low, alternates with `lo_a_n` |
| cal_pulse | output | 1 | Calibration pulse output, active high |
| rev_flag | output | 1 | Negative product seen in magnitude-only mode |

## Verification
The bench builds the block with 8-bit samples, a coarse threshold of 256, a fine threshold of 128, nominal widths of 20 and 6 cycles and a pending depth of 3. With these values a full-scale negative sample produces a fine event on every sample and a coarse event on every second sample. That makes the fixed-width, shrunk-width and back-pressure regimes reachable within a few hundred cycles, and each can be driven on purpose just by choosing the spacing between samples. The small pending depth lets back-to-back samples fill the calibration path's store, which brings the stall rules and the no-drop guarantee into play.

// File: rtl/prate_pkg.sv
package prate_pkg;

  typedef enum logic { POL_HIGH = 1'b0, POL_LOW = 1'b1 } pol_e;

  // half of a measured spacing, kept between one cycle and the nominal width
  function automatic int unsigned half_clamp(input int unsigned gap, input int unsigned nom);
    int unsigned h;
    h = gap >> 1;
    if (h < 1) h = 1;
    if (h > nom) h = nom;
    return h;
  endfunction

endpackage

// File: rtl/prate_accum.sv
module prate_accum #(
  parameter int SW     = 16,
  parameter int THRESH = 1 << 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic signed [SW-1:0] sample,
  input  logic                 mag_only,
  output logic                 ev_q,
  output logic                 flag_q
);
  localparam int AW = $clog2(THRESH) + 2;
  localparam logic signed [AW-1:0] TH = AW'(THRESH);

  logic signed [AW-1:0] acc_q, wide, addend, sum, acc_d;
  logic up, dn;

  always_comb begin
    wide   = {{(AW-SW){sample[SW-1]}}, sample};
    addend = (mag_only && sample[SW-1]) ? -wide : wide;
    sum    = acc_q + addend;
    up     = (sum >= TH);
    dn     = !mag_only && (sum <= -TH);
    if (up)      acc_d = sum - TH;
    else if (dn) acc_d = sum + TH;
    else         acc_d = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      ev_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ev_q <= 1'b0;
      if (take) begin
        acc_q <= acc_d;
        ev_q  <= up | dn;
        if (up | dn) flag_q <= mag_only & sample[SW-1];
      end
    end
  end
endmodule

// File: rtl/prate_shaper.sv
module prate_shaper #(
  parameter int W        = 1000,
  parameter int PEND_MAX = 4,
  parameter prate_pkg::pol_e POL = prate_pkg::POL_LOW,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_in,
  output logic          pulse_o,
  output logic          room_o,
  output logic [PW-1:0] pend_o
);
  localparam int GSAT = 2 * W;
  localparam int GW   = $clog2(GSAT + 1);
  localparam int CW   = $clog2(W + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q, width;
  logic [GW-1:0] gap_q, last_q, eff_gap;
  logic [PW-1:0] pend_q;
  logic [PW:0]   avail;
  logic          start;

  always_comb begin
    avail   = {1'b0, pend_q} + (PW+1)'(ev_in);
    start   = !active_q && (avail != '0);
    eff_gap = ev_in ? gap_q : last_q;
    width   = CW'(prate_pkg::half_clamp(32'(eff_gap), 32'(W)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      gap_q    <= GW'(GSAT);
      last_q   <= GW'(GSAT);
      pend_q   <= '0;
    end else begin
      pend_q <= PW'(avail - (PW+1)'(start));
      if (ev_in) begin
        last_q <= gap_q;
        gap_q  <= GW'(1);
      end else if (gap_q != GW'(GSAT)) begin
        gap_q <= gap_q + GW'(1);
      end
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= width;
      end else if (active_q) begin
        if (cnt_q == CW'(1)) active_q <= 1'b0;
        else                 cnt_q    <= cnt_q - CW'(1);
      end
    end
  end

  assign pulse_o = (POL == prate_pkg::POL_LOW) ? ~active_q : active_q;
  assign room_o  = avail < (PW+1)'(PEND_MAX);
  assign pend_o  = pend_q;
endmodule

// File: rtl/prate_gen.sv
module prate_gen #(
  parameter int SW         = 16,
  parameter int LO_THRESH  = 1 << 20,
  parameter int CAL_THRESH = 1 << 16,
  parameter int LO_W       = 275000,
  parameter int CAL_W      = 90000,
  parameter int PEND_MAX   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_data,
  input  logic          mag_only,
  output logic          lo_a_n,
  output logic          lo_b_n,
  output logic          cal_pulse,
  output logic          rev_flag
);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic          take;
  logic          lo_ev, lo_flag, cal_ev, cal_flag;
  logic          sel_q;
  logic [1:0]    lo_route, lo_pins, lo_room;
  logic [PW-1:0] pend_lo [2];
  logic [PW-1:0] pend_cal;
  logic          cal_room;

  assign take = s_valid & s_ready;

  prate_accum #(.SW(SW), .THRESH(LO_THRESH)) u_acc_lo (
    .clk(clk), .rst_n(rst_n), .take(take), .sample(s_data),
    .mag_only(mag_only), .ev_q(lo_ev), .flag_q(lo_flag));

  prate_accum #(.SW(SW), .THRESH(CAL_THRESH)) u_acc_cal (
    .clk(clk), .rst_n(rst_n), .take(take), .sample(s_data),
    .mag_only(mag_only), .ev_q(cal_ev), .flag_q(cal_flag));

  // coarse events take turns between the two low-rate outputs
  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= 1'b0;
    else if (lo_ev) sel_q <= ~sel_q;
  end

  assign lo_route = {lo_ev & sel_q, lo_ev & ~sel_q};

  for (genvar g = 0; g < 2; g++) begin : g_lo
    prate_shaper #(.W(LO_W), .PEND_MAX(PEND_MAX), .POL(prate_pkg::POL_LOW)) u_shp (
      .clk(clk), .rst_n(rst_n), .ev_in(lo_route[g]), .pulse_o(lo_pins[g]),
      .room_o(lo_room[g]), .pend_o(pend_lo[g]));
  end

  prate_shaper #(.W(CAL_W), .PEND_MAX(PEND_MAX), .POL(prate_pkg::POL_HIGH)) u_shp_cal (
    .clk(clk), .rst_n(rst_n), .ev_in(cal_ev), .pulse_o(cal_pulse),
    .room_o(cal_room), .pend_o(pend_cal));

  assign s_ready  = &lo_room & cal_room;
  assign lo_a_n   = lo_pins[0];
  assign lo_b_n   = lo_pins[1];
  assign rev_flag = lo_flag;
endmodule

// File: rtl/prate_gen_chk.sv
module prate_gen_chk #(
  parameter int SW       = 16,
  parameter int LO_W     = 275000,
  parameter int CAL_W    = 90000,
  parameter int PEND_MAX = 4,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic [SW-1:0] s_data,
  input logic          mag_only,
  input logic          lo_a_n,
  input logic          lo_b_n,
  input logic          cal_pulse,
  input logic          rev_flag,
  input logic          lo_ev,
  input logic          cal_ev,
  input logic          cal_flag,
  input logic [PW-1:0] pend_a,
  input logic [PW-1:0] pend_b,
  input logic [PW-1:0] pend_c
);
  localparam int LRW = $clog2(LO_W + 2);
  localparam int CRW = $clog2(CAL_W + 2);

  logic [LRW-1:0] run_a, run_b;
  logic [CRW-1:0] run_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_a <= '0; run_b <= '0; run_c <= '0;
    end else begin
      run_a <= !lo_a_n ? ((run_a == LRW'(LO_W + 1)) ? run_a : run_a + LRW'(1)) : '0;
      run_b <= !lo_b_n ? ((run_b == LRW'(LO_W + 1)) ? run_b : run_b + LRW'(1)) : '0;
      run_c <= cal_pulse ? ((run_c == CRW'(CAL_W + 1)) ? run_c : run_c + CRW'(1)) : '0;
    end
  end

  AST_LO_A_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_a_n |-> run_a < LRW'(LO_W));  // R7
  AST_LO_B_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_b_n |-> run_b < LRW'(LO_W));  // R7
  AST_CAL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |-> run_c < CRW'(CAL_W));  // R8
  AST_REV_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_flag != $past(rev_flag)) |-> lo_ev);  // R10
  AST_REV_MAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_flag) |-> $past(mag_only));  // R10
  AST_FLAG_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_ev && cal_ev) |-> (rev_flag == cal_flag));  // R10
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a <= PW'(PEND_MAX)) && (pend_b <= PW'(PEND_MAX)) && (pend_c <= PW'(PEND_MAX)));  // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_data)));  // R2
endmodule

bind prate_gen prate_gen_chk #(
  .SW(SW), .LO_W(LO_W), .CAL_W(CAL_W), .PEND_MAX(PEND_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .mag_only(mag_only), .lo_a_n(lo_a_n), .lo_b_n(lo_b_n), .cal_pulse(cal_pulse),
  .rev_flag(rev_flag), .lo_ev(lo_ev), .cal_ev(cal_ev), .cal_flag(cal_flag),
  .pend_a(pend_lo[0]), .pend_b(pend_lo[1]), .pend_c(pend_cal)
);

// File: tb/prate_gen_tb.sv
module prate_gen_tb;
  localparam int SW = 8, LO_T = 256, CAL_T = 128, LO_W = 20, CAL_W = 6, PMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0, s_valid = 1'b0, mag_only = 1'b1;
  logic [SW-1:0] s_data = '0;
  logic s_ready, lo_a_n, lo_b_n, cal_pulse, rev_flag;

  always #4 clk = ~clk;  // 125 MHz

  prate_gen #(.SW(SW), .LO_THRESH(LO_T), .CAL_THRESH(CAL_T), .LO_W(LO_W),
              .CAL_W(CAL_W), .PEND_MAX(PMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .mag_only(mag_only), .lo_a_n(lo_a_n), .lo_b_n(lo_b_n), .cal_pulse(cal_pulse),
    .rev_flag(rev_flag));

  int checks = 0, errors = 0;
  // bench model state
  int acc_lo = 0, acc_cal = 0, exp_a = 0, exp_b = 0, exp_c = 0, exp_rev = 0, sel = 0;
  // monitor state
  int cyc = 0, cnt_a = 0, cnt_b = 0, cnt_c = 0, cur_a = 0, cur_b = 0, cur_c = 0;
  int last_a = 0, last_b = 0, last_c = 0, t_a = 0, t_b = 0, stall_cycles = 0;
  logic pa = 1'b0, pb = 1'b0, pc = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!s_ready) stall_cycles++;
      if (!lo_a_n && !pa) begin cnt_a++; t_a = cyc; cur_a = 1; end
      else if (!lo_a_n) cur_a++;
      else if (pa) last_a = cur_a;
      if (!lo_b_n && !pb) begin cnt_b++; t_b = cyc; cur_b = 1; end
      else if (!lo_b_n) cur_b++;
      else if (pb) last_b = cur_b;
      if (cal_pulse && !pc) begin cnt_c++; cur_c = 1; end
      else if (cal_pulse) cur_c++;
      else if (pc) last_c = cur_c;
      pa = !lo_a_n; pb = !lo_b_n; pc = cal_pulse;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns 0 no event, 1 event from positive sample/direction, 2 negative
  function automatic int step(inout int acc, input int s, input bit mag, input int th);
    int add;
    add = (mag && s < 0) ? -s : s;
    acc = acc + add;
    if (acc >= th) begin acc -= th; return (mag && s < 0) ? 2 : 1; end
    if (!mag && acc <= -th) begin acc += th; return 2; end
    return 0;
  endfunction

  task automatic send(input int v, input int d, input bit chk_rev);
    int e;
    s_valid = 1'b1;
    s_data  = SW'(v);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    e = step(acc_lo, v, mag_only, LO_T);
    if (e != 0) begin
      if (sel == 0) exp_a++; else exp_b++;
      sel ^= 1;
      exp_rev = (mag_only && v < 0) ? 1 : 0;
    end
    if (step(acc_cal, v, mag_only, CAL_T) != 0) exp_c++;
    if (chk_rev) check(int'(rev_flag) == exp_rev, "R10 rev_flag after sample", int'(rev_flag), exp_rev);
    repeat (d - 1) @(negedge clk);
  endtask

  task automatic check_counts(input string tag);
    repeat (300) @(negedge clk);
    check(cnt_a == exp_a, {tag, " lo_a pulse count"}, cnt_a, exp_a);
    check(cnt_b == exp_b, {tag, " lo_b pulse count"}, cnt_b, exp_b);
    check(cnt_c == exp_c, {tag, " cal pulse count"}, cnt_c, exp_c);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(lo_a_n == 1'b1, "R1 lo_a_n idle", int'(lo_a_n), 1);
    check(lo_b_n == 1'b1, "R1 lo_b_n idle", int'(lo_b_n), 1);
    check(cal_pulse == 1'b0, "R1 cal_pulse idle", int'(cal_pulse), 0);
    check(rev_flag == 1'b0, "R1 rev_flag clear", int'(rev_flag), 0);
    check(s_ready == 1'b1, "R1 s_ready", int'(s_ready), 1);

    // slow rate, magnitude-only, negative samples: R3 R5 R6 R8 R10
    mag_only = 1'b1;
    for (int i = 0; i < 8; i++) send(-128, 50, 1'b1);
    check_counts("R3 R5 slow");
    check(last_a == LO_W, "R6 lo_a fixed width", last_a, LO_W);
    check(last_b == LO_W, "R6 lo_b fixed width", last_b, LO_W);
    check(last_c == CAL_W, "R8 cal fixed width", last_c, CAL_W);
    check((t_a - t_b == 100) || (t_b - t_a == 100), "R5 half-period spacing", t_a - t_b, 100);

    // sign-and-magnitude: cancelling pairs, then both directions (R4 R10)
    mag_only = 1'b0;
    for (int i = 0; i < 6; i++) begin send(100, 30, 1'b1); send(-100, 30, 1'b1); end
    for (int i = 0; i < 5; i++) send(127, 30, 1'b1);
    for (int i = 0; i < 10; i++) send(-127, 30, 1'b1);
    check_counts("R4 signed");
    check(rev_flag == 1'b0, "R10 flag clear in signed mode", int'(rev_flag), 0);

    // magnitude-only positive, then small negative with no crossing: flag only moves on events
    mag_only = 1'b1;
    for (int i = 0; i < 4; i++) send(127, 30, 1'b1);
    send(-1, 30, 1'b1);
    check_counts("R3 R10 positive");

    // fast rate: widths shrink to half the spacing (R7 R9)
    for (int i = 0; i < 40; i++) send(-128, 4, 1'b1);
    check_counts("R7 R9 fast");
    check(last_a == 8, "R7 lo_a shrunk width", last_a, 8);
    check(last_b == 8, "R7 lo_b shrunk width", last_b, 8);
    check(last_c == 2, "R7 cal shrunk width", last_c, 2);

    // back-to-back samples: pending fills, ready drops, nothing lost (R2 R9)
    stall_cycles = 0;
    for (int i = 0; i < 60; i++) send(-128, 1, 1'b0);
    check_counts("R2 R9 burst");
    check(stall_cycles > 0, "R2 ready deasserted under burst", stall_cycles, 1);

    // constrained random mix (R3 R4 R9 R10 R11)
    for (int blk = 0; blk < 15; blk++) begin
      mag_only = 1'($urandom_range(1));
      for (int i = 0; i < 20; i++) begin
        int v, d;
        v = int'($urandom_range(255)) - 128;
        d = int'($urandom_range(40, 1));
        send(v, d, d >= 2);
      end
    end
    check_counts("R3 R4 R9 R11 random");
    check(int'(rev_flag) == exp_rev, "R10 final flag", int'(rev_flag), exp_rev);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule